// File: doc/BRIEF.md
# Software Interrupt Entry Sequencer

This block carries out the entry into a software interrupt handler for a 16-bit processor core. When the decoder reports a software interrupt instruction, it pulses `start_i` with an 8-bit vector number. The sequencer latches that number and a snapshot of the register file. It then stores twelve context bytes on the system stack, one byte per memory cycle, through a byte-wide memory port. Next it reads three vector bytes from the vector table, which holds the program counter and the code bank of the handler. It finishes with a one-cycle `done_o` pulse. The updated program counter, code bank, status word and stack pointer are then presented for the register file to take.

No enable or pending flag exists in front of the sequencer. Every `start_i` that arrives while the block is idle begins a full entry. Software and hardware interrupts share one vector table, so a given number always reaches the same handler. The stack grows downward, with the pointer decremented before each byte write. A memory stall (`mem_ready_i` low) freezes the sequencer in its current access for as many cycles as the stall lasts.

Top module: `swi_entry_seq`

## Requirements
- R1: A `start_i` pulse while `busy_o` is low is always accepted: `busy_o` is high in the cycle after the start edge. No enable or flag input can suppress it.
- R2: Exactly 12 byte writes are issued. Write k (k = 0..11) goes to address {SSB, SSP-1-k}, taken modulo 2^16 within the bank. SSB sits in address bits 23:16 and SSP in bits 15:0.
- R3: The bytes are written in this order:
  - status word high byte, then its low byte;
  - program counter high byte, then its low byte;
  - code bank, data bank, extra bank, direct-page register;
  - accumulator bits 31:24, 23:16, 15:8, 7:0.
- R4: After the last write, exactly 3 reads are issued, at {8'hFF, 16'hFFFC - 4*n + j} for j = 0, 1, 2, where n is the latched vector number.
- R5: The first read byte becomes `pc_o[7:0]`, the second `pc_o[15:8]`, and the third `pcb_o`.
- R6: `ps_o` equals the latched status word with bit 6 (interrupt enable) cleared and bit 5 (system-stack select) set. The level field in bits 15:13 and all other bits are unchanged. The status word that is pushed is the unmodified original.
- R7: `ssp_o` equals the latched SSP minus 12, modulo 2^16.
- R8: `done_o` is high for exactly one cycle, in the last cycle that `busy_o` is high. `busy_o` is low in the following cycle.
- R9: A `start_i` pulse while `busy_o` is high, including the `done_o` cycle, is ignored. The running sequence keeps its vector and context, and no new sequence begins.
- R10: While `mem_req_o` is high and `mem_ready_i` is low, the sequencer holds its request, address, write data and write enable unchanged into the next cycle.
- R11: After reset, `busy_o`, `done_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Software interrupt instruction issued |
| vec_num_i | input | 8 | Vector number of the instruction |
| ps_i | input | 16 | Current status word |
| pc_i | input | 16 | Return program counter |
| pcb_i | input | 8 | Code bank register |
| dtb_i | input | 8 | Data bank register |
| adb_i | input | 8 | Extra data bank register |
| dpr_i | input | 8 | Direct page register |
| acc_i | input | 32 | Accumulator (high word : low word) |
| ssb_i | input | 8 | System stack bank |
| ssp_i | input | 16 | System stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 24 | Byte address (bank : offset) |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid when ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | Handler program counter |
| pcb_o | output | 8 | Handler code bank |
| ps_o | output | 16 | Updated status word |
| ssp_o | output | 16 | Updated stack pointer |

## Verification
Two events can land in the same cycle: a fresh `start_i` arriving during the `done_o` cycle of the previous entry, and a mid-sequence start arriving while a memory stall holds the sequencer. The bench raises `start_i` with a different vector number and fresh register values in the `done_o` cycle. It then confirms that `busy_o` drops, that no further memory access appears, and that the outputs keep the first entry's results. In a third of the sweep it also raises `start_i` mid-sequence while pseudo-random stalls are active. The address and data of every later access are still judged against the originally latched vector and context.

// File: rtl/swi_pkg.sv
package swi_pkg;
    parameter int DATA_W     = 8;
    parameter int OFS_W      = 16;
    parameter int BANK_W     = 8;
    parameter int ACC_W      = 32;
    parameter int CTX_BYTES  = 12;
    parameter int VEC_BYTES  = 3;
    parameter int VEC_STRIDE = 4;
    parameter logic [BANK_W-1:0] VEC_BANK = 8'hFF;
    parameter logic [OFS_W-1:0]  VEC_TOP  = 16'hFFFC;
    parameter int I_BIT = 6;
    parameter int S_BIT = 5;

    localparam int ADDR_W = BANK_W + OFS_W;
    localparam int IDX_W  = $clog2(CTX_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_VEC  = 2'd2,
        ST_DONE = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic [OFS_W-1:0]  ps;
        logic [OFS_W-1:0]  pc;
        logic [BANK_W-1:0] pcb;
        logic [BANK_W-1:0] dtb;
        logic [BANK_W-1:0] adb;
        logic [BANK_W-1:0] dpr;
        logic [ACC_W-1:0]  acc;
    } ctx_t;

    typedef struct packed {
        seq_st_e           st;
        logic [IDX_W-1:0]  idx;
        logic [OFS_W-1:0]  sp;
        logic [BANK_W-1:0] ssb;
        logic [7:0]        vnum;
        ctx_t              ctx;
        logic [OFS_W-1:0]  new_pc;
        logic [BANK_W-1:0] new_pcb;
    } seq_t;
endpackage

// File: rtl/swi_ctx_mux.sv
module swi_ctx_mux
    import swi_pkg::*;
(
    input  ctx_t               ctx_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [DATA_W-1:0]  byte_o
);
    localparam int ACC_BYTES = ACC_W / DATA_W;
    localparam int ACC_BASE  = CTX_BYTES - ACC_BYTES;

    logic [DATA_W-1:0] slot [CTX_BYTES];

    // Fixed head of the frame: status word, return PC, four bank registers.
    assign slot[0] = ctx_i.ps[15:8];
    assign slot[1] = ctx_i.ps[7:0];
    assign slot[2] = ctx_i.pc[15:8];
    assign slot[3] = ctx_i.pc[7:0];
    assign slot[4] = ctx_i.pcb;
    assign slot[5] = ctx_i.dtb;
    assign slot[6] = ctx_i.adb;
    assign slot[7] = ctx_i.dpr;

    // Accumulator tail, most significant byte first.
    for (genvar g = 0; g < ACC_BYTES; g++) begin : g_acc
        assign slot[ACC_BASE+g] = ctx_i.acc[ACC_W-1-g*DATA_W -: DATA_W];
    end

    always_comb begin
        byte_o = '0;
        for (int k = 0; k < CTX_BYTES; k++) begin
            if (idx_i == IDX_W'(k)) byte_o = slot[k];
        end
    end
endmodule

// File: rtl/swi_vec_addr.sv
module swi_vec_addr
    import swi_pkg::*;
(
    input  logic [7:0]        vnum_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int STRIDE_SH = $clog2(VEC_STRIDE);

    logic [OFS_W-1:0] entry_base;
    logic [OFS_W-1:0] entry_ofs;

    always_comb begin
        entry_base = VEC_TOP - (OFS_W'(vnum_i) << STRIDE_SH);
        entry_ofs  = entry_base + OFS_W'(idx_i);
        addr_o     = {VEC_BANK, entry_ofs};
    end
endmodule

// File: rtl/swi_flag_upd.sv
module swi_flag_upd
    import swi_pkg::*;
(
    input  logic [OFS_W-1:0] ps_i,
    output logic [OFS_W-1:0] ps_o
);
    always_comb begin
        ps_o        = ps_i;
        ps_o[I_BIT] = 1'b0;
        ps_o[S_BIT] = 1'b1;
    end
endmodule

// File: rtl/swi_entry_seq.sv
module swi_entry_seq
    import swi_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [7:0]   vec_num_i,
    input  logic [15:0]  ps_i,
    input  logic [15:0]  pc_i,
    input  logic [7:0]   pcb_i,
    input  logic [7:0]   dtb_i,
    input  logic [7:0]   adb_i,
    input  logic [7:0]   dpr_i,
    input  logic [31:0]  acc_i,
    input  logic [7:0]   ssb_i,
    input  logic [15:0]  ssp_i,
    output logic         mem_req_o,
    output logic         mem_we_o,
    output logic [23:0]  mem_addr_o,
    output logic [7:0]   mem_wdata_o,
    input  logic [7:0]   mem_rdata_i,
    input  logic         mem_ready_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [15:0]  pc_o,
    output logic [7:0]   pcb_o,
    output logic [15:0]  ps_o,
    output logic [15:0]  ssp_o
);
    localparam logic [IDX_W-1:0] CTX_LAST = IDX_W'(CTX_BYTES - 1);
    localparam logic [IDX_W-1:0] VEC_LAST = IDX_W'(VEC_BYTES - 1);

    seq_t q, d;

    logic [DATA_W-1:0] push_byte;
    logic [ADDR_W-1:0] vec_addr;
    logic [OFS_W-1:0]  sp_dec;

    swi_ctx_mux u_ctx_mux (
        .ctx_i  (q.ctx),
        .idx_i  (q.idx),
        .byte_o (push_byte)
    );

    swi_vec_addr u_vec_addr (
        .vnum_i (q.vnum),
        .idx_i  (q.idx),
        .addr_o (vec_addr)
    );

    swi_flag_upd u_flag_upd (
        .ps_i (q.ctx.ps),
        .ps_o (ps_o)
    );

    assign sp_dec = q.sp - OFS_W'(1);

    always_comb begin
        d           = q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st      = ST_PUSH;
                    d.idx     = '0;
                    d.sp      = ssp_i;
                    d.ssb     = ssb_i;
                    d.vnum    = vec_num_i;
                    d.ctx.ps  = ps_i;
                    d.ctx.pc  = pc_i;
                    d.ctx.pcb = pcb_i;
                    d.ctx.dtb = dtb_i;
                    d.ctx.adb = adb_i;
                    d.ctx.dpr = dpr_i;
                    d.ctx.acc = acc_i;
                end
            end
            ST_PUSH: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = {q.ssb, sp_dec};
                mem_wdata_o = push_byte;
                if (mem_ready_i) begin
                    d.sp = sp_dec;
                    if (q.idx == CTX_LAST) begin
                        d.st  = ST_VEC;
                        d.idx = '0;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            ST_VEC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = vec_addr;
                if (mem_ready_i) begin
                    if (q.idx == IDX_W'(0)) d.new_pc[7:0]  = mem_rdata_i;
                    if (q.idx == IDX_W'(1)) d.new_pc[15:8] = mem_rdata_i;
                    if (q.idx == VEC_LAST)  d.new_pcb      = mem_rdata_i;
                    if (q.idx == VEC_LAST) begin
                        d.st  = ST_DONE;
                        d.idx = '0;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != ST_IDLE);
    assign done_o = (q.st == ST_DONE);
    assign pc_o   = q.new_pc;
    assign pcb_o  = q.new_pcb;
    assign ssp_o  = q.sp;
endmodule

// File: rtl/swi_entry_seq_chk.sv
module swi_entry_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [23:0] mem_addr_o,
    input logic [7:0]  mem_wdata_o,
    input logic        mem_ready_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [15:0] ps_o
);
    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !done_o));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_ready_i) |=>
            (!mem_we_o || (mem_addr_o[15:0] == $past(mem_addr_o[15:0]) - 16'd1)));

    // R4
    write_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |=> (!mem_we_o));

    // R6
    flags_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!ps_o[6] && ps_o[5]));
endmodule

bind swi_entry_seq swi_entry_seq_chk u_swi_entry_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ps_o        (ps_o)
);

// File: tb/swi_entry_seq_bench.sv
`timescale 1ns/1ps
module swi_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  vec_num_i = '0;
    logic [15:0] ps_i = '0, pc_i = '0, ssp_i = '0;
    logic [7:0]  pcb_i = '0, dtb_i = '0, adb_i = '0, dpr_i = '0, ssb_i = '0;
    logic [31:0] acc_i = '0;
    logic        mem_req_o, mem_we_o, mem_ready_i = 1'b1;
    logic [23:0] mem_addr_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;
    logic        busy_o, done_o;
    logic [15:0] pc_o, ps_o, ssp_o;
    logic [7:0]  pcb_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    swi_entry_seq u_swi_entry_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_num_i(vec_num_i),
        .ps_i(ps_i), .pc_i(pc_i), .pcb_i(pcb_i), .dtb_i(dtb_i), .adb_i(adb_i),
        .dpr_i(dpr_i), .acc_i(acc_i), .ssb_i(ssb_i), .ssp_i(ssp_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
        .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .pcb_o(pcb_o),
        .ps_o(ps_o), .ssp_o(ssp_o)
    );

    function automatic logic [7:0] mem_model(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
    endfunction
    assign mem_rdata_i = mem_model(mem_addr_o);

    // Expected context of the running sequence
    logic [15:0] e_ps, e_pc, e_ssp;
    logic [7:0]  e_pcb, e_dtb, e_adb, e_dpr, e_ssb, e_vn;
    logic [31:0] e_acc;
    int          acc_cnt;
    logic        stall_en = 1'b0;
    logic [7:0]  lfsr = 8'hA7;
    logic        prev_stall = 1'b0;
    logic [23:0] prev_addr;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int k);
        case (k)
            0: return e_ps[15:8];
            1: return e_ps[7:0];
            2: return e_pc[15:8];
            3: return e_pc[7:0];
            4: return e_pcb;
            5: return e_dtb;
            6: return e_adb;
            7: return e_dpr;
            8: return e_acc[31:24];
            9: return e_acc[23:16];
            10: return e_acc[15:8];
            default: return e_acc[7:0];
        endcase
    endfunction

    function automatic logic [23:0] vaddr(input int j);
        logic [15:0] base;
        base = 16'hFFFC - ({8'd0, e_vn} << 2);
        return {8'hFF, base + 16'(j)};
    endfunction

    // Memory monitor: ready is set at the falling edge, the access is judged 1 ns later
    always @(negedge clk) begin
        mem_ready_i = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        #1;
        if (prev_stall) chk("R10 stalled address held", {8'd0, mem_addr_o}, {8'd0, prev_addr});
        prev_stall = mem_req_o && !mem_ready_i;
        prev_addr  = mem_addr_o;
        if (mem_req_o && mem_ready_i) begin
            if (acc_cnt < 12) begin
                chk("R2 write enable", {31'd0, mem_we_o}, 32'd1);
                chk("R2 push address", {8'd0, mem_addr_o},
                    {8'd0, e_ssb, e_ssp - 16'(acc_cnt + 1)});
                chk("R3 push byte", {24'd0, mem_wdata_o}, {24'd0, exp_byte(acc_cnt)});
            end else if (acc_cnt < 15) begin
                chk("R4 read enable", {31'd0, mem_we_o}, 32'd0);
                chk("R4 vector address", {8'd0, mem_addr_o}, {8'd0, vaddr(acc_cnt - 12)});
            end else begin
                chk("R9 extra access", 32'(acc_cnt), 32'd14);
            end
            acc_cnt++;
        end
    end

    task automatic run_seq(input int n);
        logic [15:0] x_pc;
        logic [7:0]  x_pcb;
        int          wait_cyc;
        e_vn  = 8'(n);
        e_ps  = 16'h1234 ^ {8'(n), ~8'(n)};
        e_pc  = 16'hC000 + 16'(n * 3);
        e_pcb = 8'(n) ^ 8'h11;
        e_dtb = 8'(n) ^ 8'h22;
        e_adb = 8'(n) ^ 8'h44;
        e_dpr = 8'(n) ^ 8'h88;
        e_acc = {8'(n), ~8'(n), 8'(n) ^ 8'h3C, 8'hA5};
        e_ssb = 8'(n + 1);
        e_ssp = 16'(n * 257);
        stall_en = n[0];
        acc_cnt  = 0;
        vec_num_i = e_vn; ps_i = e_ps; pc_i = e_pc; pcb_i = e_pcb; dtb_i = e_dtb;
        adb_i = e_adb; dpr_i = e_dpr; acc_i = e_acc; ssb_i = e_ssb; ssp_i = e_ssp;
        start_i = 1'b1;
        @(negedge clk);
        #2;
        start_i = 1'b0;
        chk("R1 busy after start", {31'd0, busy_o}, 32'd1);
        // Scramble the inputs: the latched snapshot must be used
        vec_num_i = ~e_vn; ps_i = ~e_ps; pc_i = ~e_pc; acc_i = ~e_acc; ssp_i = ~e_ssp;
        wait_cyc = 0;
        while (!done_o && wait_cyc < 200) begin
            @(negedge clk);
            #2;
            wait_cyc++;
            // R9: start raised mid-sequence
            start_i = (n % 3 == 0) && (wait_cyc == 4);
        end
        start_i = 1'b0;
        x_pc  = {mem_model(vaddr(1)), mem_model(vaddr(0))};
        x_pcb = mem_model(vaddr(2));
        chk("R8 done reached", {31'd0, done_o}, 32'd1);
        chk("R2 access count", 32'(acc_cnt), 32'd15);
        chk("R5 handler pc", {16'd0, pc_o}, {16'd0, x_pc});
        chk("R5 handler bank", {24'd0, pcb_o}, {24'd0, x_pcb});
        chk("R6 status word", {16'd0, ps_o}, {16'd0, (e_ps & ~16'h0040) | 16'h0020});
        chk("R7 stack pointer", {16'd0, ssp_o}, {16'd0, e_ssp - 16'd12});
        // R9: start raised in the done cycle is ignored
        start_i = 1'b1;
        vec_num_i = 8'(n + 7);
        @(negedge clk);
        #2;
        start_i = 1'b0;
        chk("R8 busy falls after done", {30'd0, busy_o, done_o}, 32'd0);
        @(negedge clk);
        #2;
        chk("R9 no sequence from done-cycle start", {31'd0, busy_o}, 32'd0);
        chk("R9 outputs kept", {16'd0, pc_o}, {16'd0, x_pc});
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R11
        chk("R11 reset busy", {31'd0, busy_o}, 32'd0);
        chk("R11 reset done", {31'd0, done_o}, 32'd0);
        chk("R11 reset request", {31'd0, mem_req_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int n = 0; n < 256; n++) begin
            run_seq(n);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule